// File: doc/BRIEF.md
# Fractional-N Frequency Word Controller

This block is the digital control front end of a fractional-N synthesizer. A host writes 32-bit frames over a three-wire serial port (serial clock, serial data, active-low chip select). The block keeps the integer and fractional division words and an integer-mode control bit. It drives the active division words, the modulator enable and a hop strobe into the system clock domain.

The integer word is double-buffered, so a frequency change lands at one defined instant. In fractional mode, an integer write only loads the shadow copy. The next fractional write then commits the fractional word and the shadowed integer word together. In integer mode, an integer write commits at once. Every commit is taken on the 31st falling serial clock edge of its frame. All three serial inputs are brought into the system clock domain through two-flop synchronizers and are decoded there.

Top module: `fracn_word_ctrl`

## Requirements
- R1: After reset the outputs are `int_word_o`=100, `frac_word_o`=0, `mod_en_o`=1, `hop_o`=0 and `range_err_o`=0.
- R2: A frame is sent MSB first while `csn_i` is low. The first 7 bits are the address, the next 24 bits are the data, and a 32nd pad bit is ignored. The frame takes effect on the 31st falling edge of `sclk_i`, so a frame of only 31 clocks still takes effect.
- R3: Address 0x0F is the integer register, which uses data bits 15:0. In fractional mode a write to it loads the shadow word only. The active outputs stay unchanged and no hop strobe is produced.
- R4: Address 0x10 is the fractional register, which uses all 24 data bits. In fractional mode a write to it sets `frac_word_o` to the data and `int_word_o` to the shadow integer word, both in the same cycle.
- R5: In integer mode, a write to address 0x0F sets `int_word_o` directly and produces a hop strobe.
- R6: Address 0x06 is the mode register. Data bit 13 set selects integer mode and drives `mod_en_o` low. Data bit 13 clear selects fractional mode and drives `mod_en_o` high. Mode writes never produce a hop strobe.
- R7: In integer mode, a write to address 0x10 changes no output and produces no hop strobe.
- R8: If `csn_i` rises before the 31st falling edge of `sclk_i`, the frame has no effect.
- R9: `hop_o` is high for exactly one system clock per commit. It is high in the first cycle in which the new active words are visible.
- R10: Every integer write updates `range_err_o`. The output is set when the value lies outside 36..65531 in fractional mode or outside 32..65535 in integer mode, and cleared otherwise. The value is stored either way.
- R11: A write to any other address changes no output and produces no hop strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous to clk_i |
| sdata_i | input | 1 | Serial data, sampled on the rising sclk_i edge |
| csn_i | input | 1 | Active-low frame select |
| int_word_o | output | 16 | Active integer division word |
| frac_word_o | output | 24 | Active fractional division word |
| mod_en_o | output | 1 | Delta-sigma modulator enable, low in integer mode |
| hop_o | output | 1 | One-cycle commit strobe |
| range_err_o | output | 1 | Last integer write was out of range for its mode |

## Verification
The assertions assume that the serial inputs change slowly compared with the system clock. Each level of `sclk_i` must last several system clocks, and `sdata_i` must stay stable across the rising edge, so the synchronized copies stay aligned. The bench holds each serial half period for three system clocks. It changes data only while `sclk_i` is low, and it moves `csn_i` only while `sclk_i` is low. This keeps every output change tied to a decoded frame.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 24;
  localparam int FRAME_BITS = 32;
  localparam int COMMIT_CNT = ADDR_W + DATA_W;  // falling edge that commits

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/fracn_sync.sv
module fracn_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/fracn_serial_rx.sv
module fracn_serial_rx
  import fracn_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sclk_s_i,
  input  logic   sdata_s_i,
  input  logic   csn_s_i,
  output logic   vld_o,
  output frame_t frame_o
);
  localparam int CNT_W = $clog2(FRAME_BITS) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_HIT = CNT_W'(COMMIT_CNT);

  logic                  sclk_q;
  logic [COMMIT_CNT-1:0] shift_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  rise, fall;

  assign rise = sclk_s_i & ~sclk_q;
  assign fall = ~sclk_s_i & sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      shift_q <= '0;
      cnt_q   <= '0;
      vld_o   <= 1'b0;
      frame_o <= '0;
    end else begin
      sclk_q <= sclk_s_i;
      vld_o  <= 1'b0;
      if (csn_s_i) begin
        cnt_q <= '0;
      end else begin
        if (rise) begin
          shift_q <= {shift_q[COMMIT_CNT-2:0], sdata_s_i};
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
        if (fall && cnt_q == CNT_HIT) begin
          vld_o   <= 1'b1;
          frame_o <= shift_q;
        end
      end
    end
  end
endmodule

// File: rtl/fracn_word_bank.sv
module fracn_word_bank
  import fracn_pkg::*;
#(
  parameter int                INT_W     = 16,
  parameter int                FRAC_W    = 24,
  parameter logic [ADDR_W-1:0] A_INT     = 7'h0F,
  parameter logic [ADDR_W-1:0] A_FRAC    = 7'h10,
  parameter logic [ADDR_W-1:0] A_MODE    = 7'h06,
  parameter int                MODE_BIT  = 13,
  parameter int                INT_RST   = 100,
  parameter int                FRAC_MIN  = 36,
  parameter int                FRAC_MAX  = 65531,
  parameter int                INTM_MIN  = 32,
  parameter int                INTM_MAX  = 65535
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  frame_t            frame_i,
  output logic [INT_W-1:0]  int_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              imode_o,
  output logic              hop_o,
  output logic              err_o
);
  localparam logic [INT_W:0] LO_F = (INT_W+1)'(FRAC_MIN);
  localparam logic [INT_W:0] HI_F = (INT_W+1)'(FRAC_MAX);
  localparam logic [INT_W:0] LO_I = (INT_W+1)'(INTM_MIN);
  localparam logic [INT_W:0] HI_I = (INT_W+1)'(INTM_MAX);

  logic [INT_W-1:0] shd_q;
  logic [INT_W-1:0] wr_int;
  logic [INT_W:0]   wr_ext;
  logic             legal;

  assign wr_int = frame_i.data[INT_W-1:0];
  assign wr_ext = {1'b0, wr_int};

  always_comb begin
    if (imode_o) legal = (wr_ext >= LO_I) && (wr_ext <= HI_I);
    else         legal = (wr_ext >= LO_F) && (wr_ext <= HI_F);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_o   <= INT_W'(INT_RST);
      shd_q   <= INT_W'(INT_RST);
      frac_o  <= '0;
      imode_o <= 1'b0;
      hop_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      hop_o <= 1'b0;
      if (vld_i) begin
        if (frame_i.addr == A_INT) begin
          shd_q <= wr_int;
          err_o <= ~legal;
          if (imode_o) begin
            int_o <= wr_int;
            hop_o <= 1'b1;
          end
        end else if (frame_i.addr == A_FRAC) begin
          if (!imode_o) begin
            frac_o <= frame_i.data[FRAC_W-1:0];
            int_o  <= shd_q;
            hop_o  <= 1'b1;
          end
        end else if (frame_i.addr == A_MODE) begin
          imode_o <= frame_i.data[MODE_BIT];
        end
      end
    end
  end
endmodule

// File: rtl/fracn_word_ctrl.sv
module fracn_word_ctrl
  import fracn_pkg::*;
#(
  parameter int INT_W   = 16,
  parameter int FRAC_W  = 24,
  parameter int INT_RST = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              csn_i,
  output logic [INT_W-1:0]  int_word_o,
  output logic [FRAC_W-1:0] frac_word_o,
  output logic              mod_en_o,
  output logic              hop_o,
  output logic              range_err_o
);
  logic [2:0] pins_s;
  logic       vld;
  frame_t     frame;
  logic       imode;

  fracn_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({csn_i, sclk_i, sdata_i}),
    .q_o    (pins_s)
  );

  fracn_serial_rx u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_s_i  (pins_s[1]),
    .sdata_s_i (pins_s[0]),
    .csn_s_i   (pins_s[2]),
    .vld_o     (vld),
    .frame_o   (frame)
  );

  fracn_word_bank #(.INT_W(INT_W), .FRAC_W(FRAC_W), .INT_RST(INT_RST)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (vld),
    .frame_i (frame),
    .int_o   (int_word_o),
    .frac_o  (frac_word_o),
    .imode_o (imode),
    .hop_o   (hop_o),
    .err_o   (range_err_o)
  );

  assign mod_en_o = ~imode;
endmodule

// File: rtl/fracn_word_ctrl_chk.sv
module fracn_word_ctrl_chk #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [INT_W-1:0]  int_word_o,
  input logic [FRAC_W-1:0] frac_word_o,
  input logic              mod_en_o,
  input logic              hop_o
);
  // R9: strobe never lasts two cycles
  a_r9_hop_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hop_o |=> !hop_o);

  // R4 / R5: active integer word only moves with a strobe
  a_r5_int_move_hop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(int_word_o) |-> hop_o);

  // R4: active fractional word only moves with a strobe
  a_r4_frac_move_hop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frac_word_o) |-> hop_o);

  // R6: mode change is never a hop
  a_r6_mode_no_hop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mod_en_o) |-> !hop_o);

  // R7: fractional word frozen while in integer mode
  a_r7_frac_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mod_en_o && $past(!mod_en_o)) |-> $stable(frac_word_o));
endmodule

bind fracn_word_ctrl fracn_word_ctrl_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .int_word_o  (int_word_o),
  .frac_word_o (frac_word_o),
  .mod_en_o    (mod_en_o),
  .hop_o       (hop_o)
);

// File: tb/fracn_word_ctrl_tb.sv
module fracn_word_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, sdata = 1'b0, csn = 1'b1;
  logic [15:0] int_w;
  logic [23:0] frac_w;
  logic        mod_en, hop, rerr;

  int n_chk = 0, n_fail = 0;
  int hop_seen = 0, run = 0, max_run = 0;
  bit done = 0;

  logic [15:0] e_int = 16'd100, e_shd = 16'd100;
  logic [23:0] e_frac = '0;
  logic        e_imode = 1'b0, e_err = 1'b0;
  int          e_hop = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fracn_word_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .csn_i(csn),
    .int_word_o(int_w), .frac_word_o(frac_w), .mod_en_o(mod_en),
    .hop_o(hop), .range_err_o(rerr)
  );

  always @(negedge clk) begin
    if (hop) begin
      hop_seen++;
      run++;
      if (run > max_run) max_run = run;
    end else run = 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [6:0] a, input logic [23:0] d, input int nbits);
    logic [31:0] w;
    w = {a, d, 1'b0};
    csn = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdata = w[31-i];
      tick(HALF);
      sclk = 1'b1;
      tick(HALF);
      sclk = 1'b0;
      tick(HALF);
    end
    csn = 1'b1;
    tick(12);
  endtask

  task automatic check_all(input string req);
    chk({req, " int"}, 32'(int_w), 32'(e_int));
    chk({req, " frac"}, 32'(frac_w), 32'(e_frac));
    chk({req, " mod_en"}, 32'(mod_en), 32'(!e_imode));
    chk({req, " err"}, 32'(rerr), 32'(e_err));
    chk({req, " hops"}, 32'(hop_seen), 32'(e_hop));
  endtask

  task automatic wr_int(input logic [15:0] v);
    send(7'h0F, {8'h0, v}, 32);
    e_shd = v;
    e_err = e_imode ? (v < 16'd32) : (v < 16'd36 || v > 16'd65531);
    if (e_imode) begin e_int = v; e_hop++; end
  endtask

  task automatic wr_frac(input logic [23:0] v, input int nbits);
    send(7'h10, v, nbits);
    if (!e_imode) begin e_frac = v; e_int = e_shd; e_hop++; end
  endtask

  task automatic wr_mode(input logic im);
    send(7'h06, 24'(im) << 13, 32);
    e_imode = im;
  endtask

  logic [15:0] sweep [10] = '{16'd0, 16'd31, 16'd32, 16'd35, 16'd36, 16'd37,
                              16'd65530, 16'd65531, 16'd65532, 16'd65535};

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    check_all("R1");
    chk("R1 hop low", 32'(hop), 32'd0);

    send(7'h20, 24'hFFFFFF, 32);
    check_all("R11 other address");

    wr_int(16'd500);
    check_all("R3 buffered int");

    wr_frac(24'h123456, 32);
    check_all("R4 joint commit");

    wr_int(16'd777);
    wr_frac(24'h000005, 31);
    check_all("R2 31-clock frame commits");

    send(7'h10, 24'hABCDEF, 30);
    check_all("R8 abort at 30");
    send(7'h0F, 24'h000123, 20);
    check_all("R8 abort at 20");

    for (int b = 0; b < 24; b++) begin
      wr_int(16'(200 + b));
      wr_frac(24'd1 << b, 32);
      check_all("R4 walking frac");
    end

    foreach (sweep[k]) begin
      wr_int(sweep[k]);
      check_all("R10 frac-mode range / R3");
    end
    wr_int(16'd1000);

    wr_mode(1'b1);
    check_all("R6 integer mode on");

    foreach (sweep[k]) begin
      wr_int(sweep[k]);
      check_all("R5 direct commit / R10 int-mode range");
    end

    wr_frac(24'h00BEEF, 32);
    check_all("R7 frac ignored in int mode");

    wr_int(16'd4321);
    wr_mode(1'b0);
    check_all("R6 fractional mode on");
    wr_int(16'd64);
    check_all("R3 buffered after mode switch");
    wr_frac(24'h0F0F0F, 32);
    check_all("R4 commit after mode switch");

    chk("R9 strobe width", 32'(max_run), 32'd1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule